// File: doc/BRIEF.md
# Essential-Bit Serial Multiply-Accumulate Group

The block computes the inner product of a group of unsigned fixed-point activations and signed weights. It spends one cycle on each one-bit of an activation and no cycles on its zero bits. Each lane holds one activation and its paired weight. Every cycle, a priority encoder picks the lowest remaining one-bit of the activation. A term unit shifts the sign-extended weight left by that bit index. All lanes step together, and an adder tree sums the terms of the lanes into a single 32-bit accumulator. A lane that has no one-bits left adds zero.

A group is accepted through a valid/ready handshake. The group takes as many cycles as the largest number of one-bits found in any of its lanes, with a minimum of one cycle. When the group finishes, the block pulses `done_o` with the updated sum. A long inner product is formed by feeding several groups in a row. The first group sets `first_i` to start the sum from zero, and the later groups add onto it. Activations use 4 integer and 4 fractional bits. The sum is given as a raw two's-complement count of 2^-4 units, so the scaling is applied at the output.

Top module: `ebs_mac_group`

## Requirements
- R1: `in_ready_o` is high whenever no group is in progress. A group is taken on a rising edge where `in_valid_i` and `in_ready_o` are both high, and `in_ready_o` then stays low until the group completes.
- R2: Lane i takes its activation from `act_i[8i+7:8i]` as an unsigned 8-bit code, with real value code/16. It takes its weight from `wgt_i[16i+15:16i]` as 16-bit two's complement. The lane contributes exactly code × weight, sign-extended.
- R3: Each group adds the sum of all its lane contributions to the accumulator, with the accumulator wrapping modulo 2^32.
- R4: A group takes max(1, P) cycles, where P is the largest count of one-bits in any lane's activation. Zero bits placed between one-bits cost no cycles. `done_o` is high in the cycle that follows the last of these cycles, so its rising edge comes max(1, P) clock edges after the accepting edge.
- R5: A group whose activations are all zero completes in one cycle and leaves the sum unchanged.
- R6: `done_o` is a one-cycle pulse, and `sum_o` shows the updated total while `done_o` is high.
- R7: With `first_i` high at acceptance, the accumulator restarts from zero before the group's terms are added. With `first_i` low, the group's terms are added onto the previous total.
- R8: `in_valid_i`, `act_i`, `wgt_i` and `first_i` have no effect on the result while a group is in progress.
- R9: After reset, `in_ready_o` is 1, `done_o` is 0 and `sum_o` is 0.
- R10: `sum_o` holds its value while the block is idle and no group is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A group is offered |
| in_ready_o | output | 1 | The block can take a group |
| first_i | input | 1 | Start a new sum with this group |
| act_i | input | LANES*8 | Packed unsigned activations, lane 0 in the low byte |
| wgt_i | input | LANES*16 | Packed signed weights, lane 0 in the low half-word |
| done_o | output | 1 | One-cycle pulse when a group has been added |
| sum_o | output | 32 | Accumulated sum in units of 2^-4 |

## Verification
The assertions check several properties on every cycle. Each encoder step removes exactly one one-bit, namely the lowest. A run never lasts more than eight cycles. Acceptance drops ready, and `done_o` is a single-cycle pulse that coincides with ready. The sum stays unchanged while the block is idle. The bench scenarios are the only place where the arithmetic is checked: the exact product with negative and extreme weights, the cycle count that follows the densest lane, the restart versus continuation of the sum, and the fact that input offered during a run has no effect.

// File: rtl/ebs_pkg.sv
`timescale 1ns/1ps
package ebs_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} ebs_state_e;
endpackage

// File: rtl/ebs_bit_encoder.sv
`timescale 1ns/1ps
module ebs_bit_encoder #(
  parameter int ACT_W = 8,
  localparam int IDX_W = (ACT_W > 1) ? $clog2(ACT_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             bit_vld_o,
  output logic             last_o
);
  logic [ACT_W-1:0] res_q;
  logic [ACT_W-1:0] rest;

  // lowest set bit wins: scan from the top down
  always_comb begin
    idx_o = '0;
    for (int i = ACT_W - 1; i >= 0; i--) begin
      if (res_q[i]) idx_o = IDX_W'(i);
    end
  end

  assign bit_vld_o = |res_q;
  assign rest      = res_q & (res_q - ACT_W'(1));
  assign last_o    = (rest == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= act_i;
    else if (step_i) res_q <= rest;
  end

  a_r4_one_bit_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && bit_vld_o) |=> ($countones(res_q) == $countones($past(res_q)) - 1));

  a_r4_index_is_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> res_q[idx_o]);
endmodule

// File: rtl/ebs_term_unit.sv
`timescale 1ns/1ps
module ebs_term_unit #(
  parameter int WGT_W  = 16,
  parameter int IDX_W  = 3,
  parameter int TERM_W = 24
) (
  input  logic signed [WGT_W-1:0]  wgt_i,
  input  logic        [IDX_W-1:0]  idx_i,
  input  logic                     en_i,
  output logic signed [TERM_W-1:0] term_o
);
  logic signed [TERM_W-1:0] wgt_ext;

  assign wgt_ext = TERM_W'(wgt_i);
  assign term_o  = en_i ? (wgt_ext <<< idx_i) : '0;
endmodule

// File: rtl/ebs_adder_tree.sv
`timescale 1ns/1ps
module ebs_adder_tree #(
  parameter int N     = 16,
  parameter int IN_W  = 24,
  parameter int OUT_W = 28
) (
  input  logic [N*IN_W-1:0]       terms_i,
  output logic signed [OUT_W-1:0] sum_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic signed [OUT_W-1:0] node [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < N) begin : g_used
      assign node[LEAVES-1+l] = OUT_W'($signed(terms_i[l*IN_W +: IN_W]));
    end else begin : g_pad
      assign node[LEAVES-1+l] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/ebs_mac_group.sv
`timescale 1ns/1ps
module ebs_mac_group #(
  parameter int LANES = 16,
  parameter int ACT_W = 8,
  parameter int WGT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic                   first_i,
  input  logic [LANES*ACT_W-1:0] act_i,
  input  logic [LANES*WGT_W-1:0] wgt_i,
  output logic                   done_o,
  output logic [ACC_W-1:0]       sum_o
);
  import ebs_pkg::*;

  localparam int IDX_W  = (ACT_W > 1) ? $clog2(ACT_W) : 1;
  localparam int TERM_W = WGT_W + ACT_W;
  localparam int SUM_W  = TERM_W + ((LANES > 1) ? $clog2(LANES) : 0);
  localparam int CNT_W  = $clog2(ACT_W + 1);

  ebs_state_e state_q;
  logic       accept, busy, all_last, done_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [SUM_W-1:0] tree_sum;
  logic [LANES-1:0]        lane_last;
  logic [LANES*TERM_W-1:0] terms;

  assign busy       = (state_q == ST_RUN);
  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign all_last   = &lane_last;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [WGT_W-1:0] w_q;
    logic [IDX_W-1:0]        idx;
    logic                    vld;
    logic signed [TERM_W-1:0] term;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     w_q <= '0;
      else if (accept) w_q <= wgt_i[g*WGT_W +: WGT_W];
    end

    ebs_bit_encoder #(.ACT_W(ACT_W)) u_enc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (accept),
      .act_i    (act_i[g*ACT_W +: ACT_W]),
      .step_i   (busy),
      .idx_o    (idx),
      .bit_vld_o(vld),
      .last_o   (lane_last[g])
    );

    ebs_term_unit #(.WGT_W(WGT_W), .IDX_W(IDX_W), .TERM_W(TERM_W)) u_term (
      .wgt_i (w_q),
      .idx_i (idx),
      .en_i  (vld),
      .term_o(term)
    );

    assign terms[g*TERM_W +: TERM_W] = term;
  end

  ebs_adder_tree #(.N(LANES), .IN_W(TERM_W), .OUT_W(SUM_W)) u_tree (
    .terms_i(terms),
    .sum_o  (tree_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= busy && all_last;
      if (accept) begin
        state_q <= ST_RUN;
        if (first_i) acc_q <= '0;
      end else if (busy) begin
        acc_q <= acc_q + ACC_W'(tree_sum);
        if (all_last) state_q <= ST_IDLE;
      end
    end
  end

  assign done_o = done_q;
  assign sum_o  = acc_q;

  // run-length counter for the bounded-run check
  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (accept) run_cnt <= '0;
    else if (busy)   run_cnt <= run_cnt + CNT_W'(1);
  end

  a_r4_bounded_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (32'(run_cnt) < ACT_W));

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_ready_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o);

  a_r10_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> $stable(sum_o));
endmodule

// File: tb/ebs_mac_group_test.sv
`timescale 1ns/1ps
module ebs_mac_group_test;
  localparam int LANES = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic first = 1'b0;
  logic in_ready, done;
  logic [LANES*8-1:0]  act_flat = '0;
  logic [LANES*16-1:0] wgt_flat = '0;
  logic [31:0] sum;

  always #10 clk = ~clk;

  ebs_mac_group uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .first_i(first), .act_i(act_flat), .wgt_i(wgt_flat), .done_o(done), .sum_o(sum)
  );

  int checks = 0;
  int errors = 0;
  int exp_acc = 0;
  bit finished = 1'b0;
  logic [7:0]  a_v [LANES];
  logic [15:0] w_v [LANES];

  task automatic chk(input bit ok, input string req, input longint actv, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int group_cycles();
    int m = 1;
    for (int i = 0; i < LANES; i++) if (popc(a_v[i]) > m) m = popc(a_v[i]);
    return m;
  endfunction

  function automatic int group_dot();
    int s = 0;
    for (int i = 0; i < LANES; i++) s += int'(a_v[i]) * int'($signed(w_v[i]));
    return s;
  endfunction

  task automatic pack();
    for (int i = 0; i < LANES; i++) begin
      act_flat[i*8 +: 8]   = a_v[i];
      wgt_flat[i*16 +: 16] = w_v[i];
    end
  endtask

  task automatic clear_group();
    for (int i = 0; i < LANES; i++) begin a_v[i] = 8'h00; w_v[i] = 16'h0000; end
  endtask

  task automatic run_group(input bit first_v, input bit junk, input string cyc_req, input string sum_req);
    int exp_cyc, cnt;
    @(negedge clk);
    pack();
    in_valid = 1'b1;
    first = first_v;
    while (!in_ready) @(negedge clk);
    if (first_v) exp_acc = 0;
    exp_acc = exp_acc + group_dot();
    exp_cyc = group_cycles();
    @(posedge clk);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (junk) begin
          act_flat = {LANES{8'hFF}};
          wgt_flat = {LANES{16'h7FFF}};
          first = ~first_v;
          chk(in_ready == 1'b0, "R8 ready low while busy", longint'(in_ready), 0);
        end else begin
          in_valid = 1'b0;
        end
      end
      if (done) break;
      cnt++;
    end
    in_valid = 1'b0;
    chk(done == 1'b1, "watchdog: done not seen", longint'(done), 1);
    chk(cnt == exp_cyc, cyc_req, cnt, exp_cyc);
    chk($signed(sum) == exp_acc, sum_req, longint'($signed(sum)), exp_acc);
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", longint'(done), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_0042));
    clear_group();
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 ready after reset", longint'(in_ready), 1);
    chk(done == 1'b0, "R9 done after reset", longint'(done), 0);
    chk(sum == 32'd0, "R9 sum after reset", longint'(sum), 0);
    rst_ni = 1'b1;

    // R5 all-zero group
    run_group(1'b1, 1'b0, "R5 zero group cycles", "R5 zero group sum");

    // R2 single lane, then zero group keeps the total (R5, R7)
    a_v[0] = 8'h10; w_v[0] = 16'd5;
    run_group(1'b1, 1'b0, "R4 one-bit cycles", "R2 1.0 x 5 = 80 raw");
    clear_group();
    run_group(1'b0, 1'b0, "R5 zero group cycles", "R5 zero adds nothing");

    // R4 dense: all ones, eight cycles
    for (int i = 0; i < LANES; i++) begin a_v[i] = 8'hFF; w_v[i] = 16'(i + 1); end
    run_group(1'b1, 1'b0, "R4 dense lane cycles", "R3 dense sum");

    // R4 gaps between ones are skipped
    clear_group();
    a_v[3] = 8'h81; w_v[3] = 16'hFFF9;
    run_group(1'b1, 1'b0, "R4 gap bits skipped", "R2 negative weight");

    // R2 extreme negative weights
    for (int i = 0; i < LANES; i++) begin a_v[i] = 8'hFF; w_v[i] = 16'h8000; end
    run_group(1'b1, 1'b0, "R4 extreme cycles", "R2 extreme negative sum");

    // R7 accumulate chain
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < LANES; i++) begin a_v[i] = 8'(i * 7 + g); w_v[i] = 16'(300 - i * 41); end
      run_group(1'b0, 1'b0, "R4 chain cycles", "R7 continued sum");
    end

    // R8 junk offered while busy
    for (int i = 0; i < LANES; i++) begin a_v[i] = 8'hF0; w_v[i] = 16'(i * 3 - 20); end
    run_group(1'b1, 1'b1, "R4 busy junk cycles", "R8 junk ignored");

    // R10 idle hold
    held = sum;
    repeat (5) @(negedge clk);
    chk(sum == held, "R10 sum held while idle", longint'(sum), longint'(held));
    chk(in_ready == 1'b1, "R1 ready while idle", longint'(in_ready), 1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < LANES; i++) begin
        a_v[i] = (n % 3 == 0) ? 8'($urandom & $urandom) : 8'($urandom);
        w_v[i] = 16'($urandom);
      end
      run_group(($urandom % 4) == 0, (n % 5) == 0, "R4 random cycles", "R3 random sum");
    end

    summary();
  end
endmodule